// File: doc/BRIEF.md
# Static Memory Access Timing Sequencer

This block runs one asynchronous read or write at a time against an external static memory: SRAM, ROM or parallel NOR flash. A host asks for an access through a valid/ready request channel. The block answers with a single-cycle completion pulse that carries the read data. In between, it drives chip select, output enable, write enable, an address-valid strobe, the address bus and a bidirectional data bus. It moves through up to three phases: address setup, address hold and data.

The length of each phase, in host clock cycles, comes from a 16-bit timing word. Software loads that word through a plain write strobe. The block copies the word when it accepts a request, so a load made during an access only affects later accesses.

Two behaviours depend on the kind of access:
- In multiplexed mode, the low data lines carry the address during setup and hold.
- A write gets one extra data cycle, and write enable is released in that last cycle so the data is held after the strobe.

An active-high wait input from the memory stretches the data phase.

The request channel accepts a request only while `req_ready` is high. `req_ready` is high exactly when no access is in progress. The host must keep `req_valid` and the request fields stable until it sees `req_ready` high at a clock edge. The completion pulse has no back-pressure, so the host must take it in the cycle it appears.

Top module: `smc_access_seq`

## Requirements
- R1: After reset, every memory strobe is inactive (high), `req_ready` is high and `rsp_valid` is low. The timing word resets to 16'hFFFF, which gives setup 15, hold 15 and data 255.
- R2: The setup phase lasts exactly the setup code (timing bits 3:0) in cycles, with `mem_adv_n` low for the whole phase. A code of 0 skips the phase, and `mem_adv_n` then never goes low.
- R3: The hold phase occurs only in multiplexed mode, between setup and data. It lasts the hold code (bits 7:4) in cycles, and a code of 0 counts as 1.
- R4: A read data phase lasts the data code (bits 15:8) in cycles, and a code of 0 counts as 1. `mem_oe_n` is low for exactly the read data phase.
- R5: A write data phase lasts one cycle more than the effective data code. `mem_we_n` is low in every write data cycle except the last one, and it is never low at the same time as `mem_oe_n`.
- R6: Each cycle in which `mem_wait` is high during the data phase lengthens that phase by one cycle. For a write, each such cycle before the final one also lengthens the low time of `mem_we_n`.
- R7: `mem_cs_n` is low for exactly setup + hold + data cycles. `rsp_valid` pulses for one cycle in the cycle right after `mem_cs_n` rises. For a read, `rsp_rdata` then holds the `mem_dq_in` value from the last data cycle.
- R8: A request is accepted only when `req_ready` is high, which is only when the sequencer is idle (`mem_cs_n` high). The phase lengths of an access come from the timing word as it stood when the request was accepted.
- R9: In multiplexed mode, during setup and hold, `mem_dq_oe` is high and `mem_dq_out` carries the low address bits. During a write data phase, `mem_dq_out` carries the write data with `mem_dq_oe` high. During a read data phase, `mem_dq_oe` is low. `mem_addr` holds the request address for the whole access.
- R10: A cycle with `tim_wr_en` high loads `tim_wr_data` into the timing word. The fields sit at bits 15:8 (data), 7:4 (hold) and 3:0 (setup).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tim_wr_en | input | 1 | Load strobe for the timing word |
| tim_wr_data | input | 16 | New timing word |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mux | input | 1 | 1 = multiplexed address/data mode |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data bus value driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data bus value from memory |
| mem_wait | input | 1 | Memory not ready, stretches the data phase |

## Verification
The hardest situation to reach is a wait request that lands at a chosen point inside the data phase while the timing word is being rewritten underneath the running access. Only in that situation do the counter freeze and the snapshot of the timing word both matter.

The bench works out, for every access, the cycle index at which the data phase begins, using the setup and hold codes it loaded. It raises `mem_wait` for a fixed number of cycles from that index, and in one scenario it loads a new timing word two cycles into the access. Strobe low times and the cycle of the completion pulse are then compared with figures derived from the old timing word. The next access, with no reload, is compared with figures derived from the new one.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int SETUP_W = 4;
  localparam int HOLD_W  = 4;
  localparam int DPH_W   = 8;
  localparam int TIM_W   = DPH_W + HOLD_W + SETUP_W;
  localparam int CNT_W   = DPH_W + 1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  // Field order in the word is fixed: data 15:8, hold 7:4, setup 3:0
  typedef struct packed {
    logic [DPH_W-1:0]   dph;
    logic [HOLD_W-1:0]  hold;
    logic [SETUP_W-1:0] setup;
  } tim_t;

  localparam tim_t TIM_RESET = tim_t'({TIM_W{1'b1}});

  function automatic logic [CNT_W-1:0] hold_len(tim_t t);
    return (t.hold == '0) ? CNT_W'(1) : CNT_W'(t.hold);
  endfunction

  function automatic logic [CNT_W-1:0] data_len(tim_t t, logic wr);
    logic [CNT_W-1:0] base;
    base = (t.dph == '0) ? CNT_W'(1) : CNT_W'(t.dph);
    return base + CNT_W'(wr);
  endfunction
endpackage

// File: rtl/smc_timing_reg.sv
module smc_timing_reg
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TIM_W-1:0] wr_data,
  output tim_t             tim_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tim_o <= TIM_RESET;
    else if (wr_en) tim_o <= tim_t'(wr_data);
  end
endmodule

// File: rtl/smc_phase_fsm.sv
module smc_phase_fsm
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_fire,
  input  logic             acc_write,
  input  logic             acc_mux,
  input  tim_t             acc_tim,
  input  logic             mem_wait,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_wr_o,
  output logic             act_mux_o,
  output logic             data_end_o
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  tim_t             act_tim;
  logic             act_wr;
  logic             act_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      act_tim <= TIM_RESET;
      act_wr  <= 1'b0;
      act_mux <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (acc_fire) begin
          act_tim <= acc_tim;
          act_wr  <= acc_write;
          act_mux <= acc_mux;
          if (acc_tim.setup != '0) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(acc_tim.setup);
          end else if (acc_mux) begin
            phase <= PH_HOLD;
            cnt   <= hold_len(acc_tim);
          end else begin
            phase <= PH_DATA;
            cnt   <= data_len(acc_tim, acc_write);
          end
        end
        PH_SETUP: begin
          if (cnt == CNT_W'(1)) begin
            if (act_mux) begin
              phase <= PH_HOLD;
              cnt   <= hold_len(act_tim);
            end else begin
              phase <= PH_DATA;
              cnt   <= data_len(act_tim, act_wr);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == CNT_W'(1)) begin
            phase <= PH_DATA;
            cnt   <= data_len(act_tim, act_wr);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (!mem_wait) begin
            if (cnt == CNT_W'(1)) begin
              phase <= PH_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign phase_o    = phase;
  assign cnt_o      = cnt;
  assign act_wr_o   = act_wr;
  assign act_mux_o  = act_mux;
  assign data_end_o = (phase == PH_DATA) && (cnt == CNT_W'(1)) && !mem_wait;

  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && mem_wait) |=> (phase == PH_DATA && $stable(cnt))); // R6
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (cnt != '0)); // R4
  AST_TIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(act_tim)); // R8
  AST_SKIP_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && acc_fire && acc_tim.setup == '0) |=> (phase != PH_SETUP)); // R2
endmodule

// File: rtl/smc_pin_drive.sv
module smc_pin_drive
  import smc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              act_wr,
  input  logic              act_mux,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam int MUX_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

  logic              in_addr_ph;
  logic [DATA_W-1:0] addr_on_dq;

  generate
    if (ADDR_W >= DATA_W) begin : g_trunc
      assign addr_on_dq = lat_addr[MUX_W-1:0];
    end else begin : g_pad
      assign addr_on_dq = {{(DATA_W-ADDR_W){1'b0}}, lat_addr};
    end
  endgenerate

  assign in_addr_ph = (phase == PH_SETUP) || (phase == PH_HOLD);

  always_comb begin
    mem_cs_n   = (phase == PH_IDLE);
    mem_adv_n  = (phase != PH_SETUP);
    mem_oe_n   = !((phase == PH_DATA) && !act_wr);
    mem_we_n   = !((phase == PH_DATA) && act_wr && (cnt > CNT_W'(1)));
    mem_addr   = lat_addr;
    mem_dq_oe  = (act_mux && in_addr_ph) || (act_wr && phase == PH_DATA);
    mem_dq_out = (act_mux && in_addr_ph) ? addr_on_dq : lat_wdata;
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R5
  AST_CS_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n || !mem_adv_n) |-> !mem_cs_n); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R9
endmodule

// File: rtl/smc_access_seq.sv
module smc_access_seq
  import smc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tim_wr_en,
  input  logic [TIM_W-1:0]  tim_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_mux,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_wait
);
  tim_t             tim_q;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             act_wr, act_mux, data_end, acc_fire;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  assign req_ready = (phase == PH_IDLE);
  assign acc_fire  = req_valid && req_ready;

  smc_timing_reg u_tim (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tim_wr_en),
    .wr_data (tim_wr_data),
    .tim_o   (tim_q)
  );

  smc_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_fire   (acc_fire),
    .acc_write  (req_write),
    .acc_mux    (req_mux),
    .acc_tim    (tim_q),
    .mem_wait   (mem_wait),
    .phase_o    (phase),
    .cnt_o      (cnt),
    .act_wr_o   (act_wr),
    .act_mux_o  (act_mux),
    .data_end_o (data_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (acc_fire) begin
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      rsp_valid <= data_end;
      if (data_end && !act_wr) rsp_rdata <= mem_dq_in;
    end
  end

  smc_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .cnt        (cnt),
    .act_wr     (act_wr),
    .act_mux    (act_mux),
    .lat_addr   (lat_addr),
    .lat_wdata  (lat_wdata),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_adv_n  (mem_adv_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n); // R8
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_cs_n && $past(!mem_cs_n))); // R7
endmodule

// File: tb/smc_access_seq_tb_top.sv
module smc_access_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tim_wr_en = 1'b0;
  logic [15:0]   tim_wr_data = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_mux = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 16'h5A00;
  logic          mem_wait = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) mem_dq_in <= mem_dq_in + 16'h0123;

  smc_access_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tim_wr_en(tim_wr_en), .tim_wr_data(tim_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_mux(req_mux), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
  );

  task automatic check(string req, string what, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One access; expectations come from 'word' (the timing in force at acceptance)
  task automatic run_acc(bit wr, bit mux, logic [AW-1:0] addr, logic [DW-1:0] wdata,
                         logic [15:0] word, bit load, int w, bit mid, logic [15:0] mid_word);
    int s, hp, dp, ds, total;
    int i, c_cs, c_adv, c_oe, c_we, rsp_i, rdy_err, bus_err;
    logic [DW-1:0] last_rd, got;
    bit done;
    s  = int'(word[3:0]);
    hp = mux ? ((word[7:4] == 0) ? 1 : int'(word[7:4])) : 0;
    dp = ((word[15:8] == 0) ? 1 : int'(word[15:8])) + (wr ? 1 : 0);
    ds = s + hp;
    total = ds + dp + w;
    if (load) begin
      @(negedge clk); tim_wr_en = 1'b1; tim_wr_data = word;   // R10 load
      @(negedge clk); tim_wr_en = 1'b0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mux = mux; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    i = 0; c_cs = 0; c_adv = 0; c_oe = 0; c_we = 0; rsp_i = -1;
    rdy_err = 0; bus_err = 0; done = 0; last_rd = '0; got = '0;
    while (!done) begin
      mem_wait = (i >= ds) && (i < ds + w);
      if (mid && i == 1) begin tim_wr_en = 1'b1; tim_wr_data = mid_word; end
      if (mid && i == 2) tim_wr_en = 1'b0;
      if (rsp_valid) begin
        done = 1; rsp_i = i; got = rsp_rdata;
      end else begin
        if (!mem_cs_n)  c_cs++;
        if (!mem_adv_n) c_adv++;
        if (!mem_oe_n) begin c_oe++; last_rd = mem_dq_in; end
        if (!mem_we_n)  c_we++;
        if (req_ready && !mem_cs_n) rdy_err++;
        if (mem_addr != addr) bus_err++;
        if (mux && i < ds && !(mem_dq_oe && mem_dq_out == addr[DW-1:0])) bus_err++;
        if (i >= ds && i < total) begin
          if (wr && !(mem_dq_oe && mem_dq_out == wdata)) bus_err++;
          if (!wr && mem_dq_oe) bus_err++;
        end
      end
      @(negedge clk);
      i++;
    end
    mem_wait = 1'b0;
    check("R7", "cs low cycles", c_cs == total, c_cs, total);
    check("R2", "adv low cycles", c_adv == s, c_adv, s);
    check("R4", "oe low cycles", c_oe == (wr ? 0 : dp + w), c_oe, wr ? 0 : dp + w);
    check("R5", "we low cycles", c_we == (wr ? dp - 1 + w : 0), c_we, wr ? dp - 1 + w : 0);
    check("R7", "done cycle index", rsp_i == total, rsp_i, total);
    check("R7", "done pulse width", rsp_valid == 1'b0, int'(rsp_valid), 0);
    check("R8", "ready during access", rdy_err == 0, rdy_err, 0);
    check("R9", "bus content errors", bus_err == 0, bus_err, 0);
    if (!wr) check("R7", "read data", got == last_rd, int'(got), int'(last_rd));
  endtask

  task automatic t_reset_default();
    check("R1", "cs_n", mem_cs_n == 1'b1, int'(mem_cs_n), 1);
    check("R1", "oe_n", mem_oe_n == 1'b1, int'(mem_oe_n), 1);
    check("R1", "we_n", mem_we_n == 1'b1, int'(mem_we_n), 1);
    check("R1", "adv_n", mem_adv_n == 1'b1, int'(mem_adv_n), 1);
    check("R1", "ready", req_ready == 1'b1, int'(req_ready), 1);
    check("R1", "rsp_valid", rsp_valid == 1'b0, int'(rsp_valid), 0);
    // R1: default word 16'hFFFF governs the first access
    run_acc(1'b0, 1'b0, 24'h123456, '0, 16'hFFFF, 1'b0, 0, 1'b0, '0);
  endtask

  task automatic t_plain_read();   // R2 R4
    run_acc(1'b0, 1'b0, 24'h00A5A5, '0, 16'h0302, 1'b1, 0, 1'b0, '0);
  endtask
  task automatic t_reserved_read(); // R2 skip, R4 code 0
    run_acc(1'b0, 1'b0, 24'h000010, '0, 16'h0000, 1'b1, 0, 1'b0, '0);
  endtask
  task automatic t_plain_write();   // R5
    run_acc(1'b1, 1'b0, 24'h0F0F0F, 16'hBEEF, 16'h0101, 1'b1, 0, 1'b0, '0);
  endtask
  task automatic t_mux_read();      // R3 R9
    run_acc(1'b0, 1'b1, 24'hABCDEF, '0, 16'h0423, 1'b1, 0, 1'b0, '0);
  endtask
  task automatic t_mux_write_h0();  // R3 hold code 0
    run_acc(1'b1, 1'b1, 24'h113355, 16'hC0DE, 16'h0200, 1'b1, 0, 1'b0, '0);
  endtask
  task automatic t_wait_read();     // R6
    run_acc(1'b0, 1'b0, 24'h000777, '0, 16'h0201, 1'b1, 3, 1'b0, '0);
  endtask
  task automatic t_wait_mux_write(); // R6 R9
    run_acc(1'b1, 1'b1, 24'h246802, 16'h1234, 16'h0312, 1'b1, 2, 1'b0, '0);
  endtask
  task automatic t_snapshot();      // R8 R10
    run_acc(1'b0, 1'b0, 24'h000099, '0, 16'h0502, 1'b1, 0, 1'b1, 16'h0131);
    run_acc(1'b0, 1'b1, 24'h00AA55, '0, 16'h0131, 1'b0, 1, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_default();
    t_plain_read();
    t_reserved_read();
    t_plain_write();
    t_mux_read();
    t_mux_write_h0();
    t_wait_read();
    t_wait_mux_write();
    t_snapshot();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule